// File: doc/BRIEF.md
# Byte-Stream GPIO Command Decoder

This block sits behind a host-side receive FIFO and turns a stream of command bytes into the settings of two 8-bit bidirectional pin groups, a low group and a high group. Each group has an output-value register, an output-enable register and a synchronised sample of its pin levels. A set command carries an opcode and two operand bytes, the drive value and then the direction mask. Once the last operand byte arrives, the decoder updates the selected group's value and enable registers together.

A get command returns one byte of the selected group's sampled pin levels on a response byte stream. Until that byte is taken, the decoder accepts no further input. Any opcode byte that is not one of the four known codes is consumed and dropped. It changes no state and produces no response.

Top module: `gpio_cmd_decoder`

## Requirements
- R1: After reset both groups drive an output value of 0x00 with output enable 0x00 (all pins inputs), `out_valid` is low and `in_ready` is high.
- R2: Opcode 0x80 followed by bytes V then D sets the low group so that `lo_out`=V and `lo_oe`=D from the cycle after D is accepted. An enable bit of 1 makes that pin an output and 0 makes it an input. Operand bytes are data even when they equal an opcode value.
- R3: Opcode 0x82 followed by V then D sets the high group in the same way (`hi_out`=V, `hi_oe`=D) and leaves the low group unchanged.
- R4: A set command changes nothing after its opcode or its value byte alone. The value and enable registers of a group change only together, on the cycle the direction byte is accepted.
- R5: Opcode 0x81 returns one response byte equal to the low group's pin levels. Opcode 0x83 does the same for the high group. The pin levels are sampled through SYNC_STAGES flops and must be steady for at least SYNC_STAGES+1 cycles before the opcode is accepted.
- R6: While a response byte is pending, `in_ready` is low and `out_valid` and `out_data` hold steady until `out_ready` is seen high.
- R7: A byte in the opcode position outside 0x80..0x83 is accepted and dropped. It leaves both groups unchanged and produces no response, and the following byte is decoded as an opcode.
- R8: Each get command yields exactly one response byte: `out_valid` is low in the cycle after the byte is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command byte available |
| in_ready | output | 1 | Decoder accepts the command byte |
| in_data | input | 8 | Command byte |
| out_valid | output | 1 | Response byte available |
| out_ready | input | 1 | Consumer takes the response byte |
| out_data | output | 8 | Response byte (sampled pin levels) |
| lo_out | output | 8 | Low group output value |
| lo_oe | output | 8 | Low group output enable, 1 = drive |
| lo_in | input | 8 | Low group pin levels |
| hi_out | output | 8 | High group output value |
| hi_oe | output | 8 | High group output enable, 1 = drive |
| hi_in | input | 8 | High group pin levels |

## Verification
The bench builds the block with the default SYNC_STAGES of 2. It models each pin as the driven value where enabled and an external level elsewhere, so reads show both driven and floating pins. Random mixes of set, get and unknown opcodes cover both groups, including operand bytes equal to opcode values. Randomly delayed response acceptance holds the stall window open for several cycles.

// File: rtl/gpio_cmd_pkg.sv
package gpio_cmd_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_PORTS = 2;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [1:0] {
    ST_OPC  = 2'd0,
    ST_VAL  = 2'd1,
    ST_DIR  = 2'd2,
    ST_RESP = 2'd3
  } dec_state_e;

  // Known opcodes are 0x80..0x83: bit 0 selects get, bit 1 selects the group.
  function automatic logic op_known(byte_t b);
    return b[BYTE_W-1:2] == 6'b100000;
  endfunction

  function automatic logic op_is_get(byte_t b);
    return b[0];
  endfunction

  function automatic logic op_port(byte_t b);
    return b[1];
  endfunction
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pins_raw,
  output logic [WIDTH-1:0] pins_sync
);
  logic [WIDTH-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[0] <= '0;
          else        chain_q[0] <= pins_raw;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign pins_sync = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_cmd_parser.sv
module gpio_cmd_parser
  import gpio_cmd_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  output logic                              in_ready,
  input  byte_t                             in_data,
  output logic                              out_valid,
  input  logic                              out_ready,
  output byte_t                             out_data,
  input  logic [NUM_PORTS-1:0][BYTE_W-1:0]  pins_sampled,
  output logic [NUM_PORTS-1:0]              commit_vec,
  output byte_t                             commit_val,
  output byte_t                             commit_dir
);
  dec_state_e state_q;
  logic       port_q;
  byte_t      val_q;
  byte_t      resp_q;

  logic byte_take;
  logic take_opc;
  logic take_dir;
  logic resp_done;

  assign in_ready  = (state_q != ST_RESP);
  assign out_valid = (state_q == ST_RESP);
  assign out_data  = resp_q;

  assign byte_take = in_valid && in_ready;
  assign take_opc  = byte_take && (state_q == ST_OPC);
  assign take_dir  = byte_take && (state_q == ST_DIR);
  assign resp_done = out_valid && out_ready;

  always_comb begin
    commit_vec = '0;
    if (take_dir) commit_vec[port_q] = 1'b1;
  end
  assign commit_val = val_q;
  assign commit_dir = in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_OPC;
      port_q  <= 1'b0;
      val_q   <= '0;
      resp_q  <= '0;
    end else begin
      case (state_q)
        ST_OPC: if (take_opc && op_known(in_data)) begin
          port_q <= op_port(in_data);
          if (op_is_get(in_data)) begin
            resp_q  <= pins_sampled[op_port(in_data)];
            state_q <= ST_RESP;
          end else begin
            state_q <= ST_VAL;
          end
        end
        ST_VAL: if (byte_take) begin
          val_q   <= in_data;
          state_q <= ST_DIR;
        end
        ST_DIR: if (take_dir) state_q <= ST_OPC;
        ST_RESP: if (resp_done) state_q <= ST_OPC;
        default: state_q <= ST_OPC;
      endcase
    end
  end

  // R7: an unknown opcode byte leaves the decoder waiting for an opcode with no response.
  assert_drop_unknown_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take_opc && !op_known(in_data) |=> (state_q == ST_OPC) && !out_valid);

  // R6: a pending response byte does not move until taken.
  assert_resp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && !in_ready);

  // R8: one response byte per get command.
  assert_single_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resp_done |=> !out_valid);
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
  import gpio_cmd_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_PORTS-1:0]              commit_vec,
  input  byte_t                             commit_val,
  input  byte_t                             commit_dir,
  output logic [NUM_PORTS-1:0][BYTE_W-1:0]  drv_val,
  output logic [NUM_PORTS-1:0][BYTE_W-1:0]  drv_oe
);
  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          drv_val[p] <= '0;
          drv_oe[p]  <= '0;
        end else if (commit_vec[p]) begin
          drv_val[p] <= commit_val;
          drv_oe[p]  <= commit_dir;
        end
      end

      // R4: no change to a group without a completed set command for it.
      assert_hold_partial_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_vec[p] |=> $stable(drv_val[p]) && $stable(drv_oe[p]));
    end
  endgenerate

  // R3: one group at most is written per completed command.
  assert_one_group_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(commit_vec));
endmodule

// File: rtl/gpio_cmd_decoder.sv
module gpio_cmd_decoder
  import gpio_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic [7:0] lo_out,
  output logic [7:0] lo_oe,
  input  logic [7:0] lo_in,
  output logic [7:0] hi_out,
  output logic [7:0] hi_oe,
  input  logic [7:0] hi_in
);
  localparam int PIN_W = NUM_PORTS * BYTE_W;

  logic [PIN_W-1:0]                  pins_raw;
  logic [PIN_W-1:0]                  pins_sync;
  logic [NUM_PORTS-1:0][BYTE_W-1:0]  pins_sampled;
  logic [NUM_PORTS-1:0]              commit_vec;
  byte_t                             commit_val;
  byte_t                             commit_dir;
  logic [NUM_PORTS-1:0][BYTE_W-1:0]  drv_val;
  logic [NUM_PORTS-1:0][BYTE_W-1:0]  drv_oe;

  assign pins_raw     = {hi_in, lo_in};
  assign pins_sampled = pins_sync;

  gpio_pin_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pins_raw  (pins_raw),
    .pins_sync (pins_sync)
  );

  gpio_cmd_parser u_parser (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_data      (in_data),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_data     (out_data),
    .pins_sampled (pins_sampled),
    .commit_vec   (commit_vec),
    .commit_val   (commit_val),
    .commit_dir   (commit_dir)
  );

  gpio_port_bank u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit_vec (commit_vec),
    .commit_val (commit_val),
    .commit_dir (commit_dir),
    .drv_val    (drv_val),
    .drv_oe     (drv_oe)
  );

  assign lo_out = drv_val[0];
  assign lo_oe  = drv_oe[0];
  assign hi_out = drv_val[1];
  assign hi_oe  = drv_oe[1];

  // R2: a completed low-group command shows its operands on the pins next cycle.
  assert_low_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
    commit_vec[0] |=> (lo_oe == $past(commit_dir)) && (lo_out == $past(commit_val)));
endmodule

// File: tb/gpio_cmd_decoder_bench.sv
module gpio_cmd_decoder_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_data;
  logic [7:0] lo_out, lo_oe, hi_out, hi_oe;
  logic [7:0] lo_in, hi_in;
  logic [7:0] ext_lo = 8'h00, ext_hi = 8'h00;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  logic [7:0] m_val [2];
  logic [7:0] m_oe  [2];

  always #5 clk = ~clk;

  function automatic logic [7:0] pin_level(logic [7:0] oe, logic [7:0] drv, logic [7:0] ext);
    return (oe & drv) | (~oe & ext);
  endfunction

  assign lo_in = pin_level(lo_oe, lo_out, ext_lo);
  assign hi_in = pin_level(hi_oe, hi_out, ext_hi);

  gpio_cmd_decoder #(.SYNC_STAGES(2)) u_gpio_cmd_decoder (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .lo_out(lo_out), .lo_oe(lo_oe), .lo_in(lo_in),
    .hi_out(hi_out), .hi_oe(hi_oe), .hi_in(hi_in)
  );

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_checks = n_checks + 1;
      n_fail   = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
      report();
      $finish;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_checks = n_checks + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic chk_ports(string tag);
    chk({tag, " lo_out"}, lo_out, m_val[0]);
    chk({tag, " lo_oe"},  lo_oe,  m_oe[0]);
    chk({tag, " hi_out"}, hi_out, m_val[1]);
    chk({tag, " hi_oe"},  hi_oe,  m_oe[1]);
  endtask

  task automatic send_byte(logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_set(int p, logic [7:0] v, logic [7:0] d);
    send_byte(p == 0 ? 8'h80 : 8'h82);
    chk_ports("R4 after opcode");
    send_byte(v);
    chk_ports("R4 after value");
    send_byte(d);
    m_val[p] = v;
    m_oe[p]  = d;
    chk_ports(p == 0 ? "R2 low set" : "R3 high set");
  endtask

  task automatic do_get(int p);
    logic [7:0] exp;
    int waitc;
    repeat (4) @(negedge clk);
    exp = (p == 0) ? pin_level(m_oe[0], m_val[0], ext_lo) : pin_level(m_oe[1], m_val[1], ext_hi);
    send_byte(p == 0 ? 8'h81 : 8'h83);
    waitc = $urandom_range(0, 3);
    for (int k = 0; k < waitc; k++) begin
      chk("R6 valid while pending", {7'd0, out_valid}, 8'h01);
      chk("R6 stall input", {7'd0, in_ready}, 8'h00);
      @(negedge clk);
    end
    chk("R5 response valid", {7'd0, out_valid}, 8'h01);
    chk(p == 0 ? "R5 low pins" : "R5 high pins", out_data, exp);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R8 single response", {7'd0, out_valid}, 8'h00);
  endtask

  task automatic do_junk(logic [7:0] b);
    if (b[7:2] == 6'b100000) b = b ^ 8'h40;
    send_byte(b);
    chk("R7 no response", {7'd0, out_valid}, 8'h00);
    chk_ports("R7 unchanged");
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    m_val[0] = 8'h00; m_val[1] = 8'h00; m_oe[0] = 8'h00; m_oe[1] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_ports("R1 reset");
    chk("R1 out_valid", {7'd0, out_valid}, 8'h00);
    chk("R1 in_ready", {7'd0, in_ready}, 8'h01);

    ext_lo = 8'hA5; ext_hi = 8'h3C;
    do_get(0);
    do_get(1);
    do_set(0, 8'h81, 8'h83);
    do_set(1, 8'h80, 8'h82);
    do_get(0);
    do_get(1);
    do_junk(8'h00);
    do_junk(8'hFF);
    do_junk(8'h84);
    send_byte(8'h7F);
    do_set(0, 8'hF0, 8'hFF);
    do_get(0);
    do_set(1, 8'h55, 8'h0F);
    do_get(1);

    for (int i = 0; i < 300; i++) begin
      int sel;
      sel = $urandom_range(0, 5);
      if ($urandom_range(0, 3) == 0) begin
        ext_lo = 8'($urandom);
        ext_hi = 8'($urandom);
      end
      case (sel)
        0: do_set(0, 8'($urandom), 8'($urandom));
        1: do_set(1, 8'($urandom), 8'($urandom));
        2: do_get(0);
        3: do_get(1);
        default: do_junk(8'($urandom));
      endcase
    end

    report();
    $finish;
  end
endmodule